// File: doc/BRIEF.md
# Bus Master Protected Region Filter

This block sits in the request path of one bus master, in front of the system interconnect. It keeps that master out of a single memory window that software sets up. The window is described by two configuration values. The first is a 32-bit base word whose least significant bit switches protection on. The second is a 5-bit exponent code that selects a power-of-two window size.

Each request the master offers is compared with the window. A request whose address falls inside an enabled window is accepted locally and is not forwarded. It is answered one cycle later with an error response and zero read data. Every other request goes to the downstream port unchanged. Its response comes back to the master with the downstream error flag intact.

Only one transaction is in flight at a time, so responses always return in request order. Configuration is written through a simple write port. A new setting governs every request accepted after the write cycle.

Top module: `prot_region_filter`

## Requirements
- R1: After reset both configuration values are zero, so protection is off. No response and no downstream request is pending, and the first request is forwarded.
- R2: While bit 0 of the base word is 0, every address is forwarded, including addresses inside the configured window.
- R3: While protection is on, a request whose address lies inside the window is accepted with ready high and never appears on the downstream port. In the cycle after the handshake the master sees response valid, error flag 1 and read data 0.
- R4: The size code c selects a window of 2^(c+1) bytes for the defined codes 13 to 18 (16 KB to 512 KB) and 22 (8 MB). With N = c+1, an address is inside the window when its bits [31:N] equal base bits [31:N]. The last byte of the window is blocked, and the bytes just below and just above the window are forwarded.
- R5: Size codes 12, 19, 20, 21, 23 and 24, and every code below 12 or above 24, mean "no window". With these codes all requests are forwarded, even while protection is on.
- R6: Base bits below N, apart from bit 0, are ignored in the comparison even when they hold ones.
- R7: A forwarded request shows the master's address, write flag and write data unchanged on the downstream port. The master's ready follows downstream ready.
- R8: After a downstream handshake, no new downstream request is issued until the response returns. That response reaches the master in the same cycle, with read data and error flag copied.
- R9: A configuration write has no effect on a request accepted in the same cycle, nor on a request already in flight. It applies from the next accepted request on.
- R10: A configuration write with select 0 loads the whole 32-bit base word. With select 1 it loads the size code from write-data bits [4:0], and the other bits are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the base word, 1 selects the size code |
| cfg_wdata | input | 32 | Configuration write data |
| m_req_valid | input | 1 | Master request valid |
| m_req_ready | output | 1 | Master request ready |
| m_req_addr | input | 32 | Master request byte address |
| m_req_write | input | 1 | Master request is a write |
| m_req_wdata | input | 32 | Master write data |
| m_rsp_valid | output | 1 | Response valid toward the master |
| m_rsp_rdata | output | 32 | Read data toward the master |
| m_rsp_err | output | 1 | Error flag toward the master |
| s_req_valid | output | 1 | Downstream request valid |
| s_req_ready | input | 1 | Downstream request ready |
| s_req_addr | output | 32 | Downstream request address |
| s_req_write | output | 1 | Downstream request is a write |
| s_req_wdata | output | 32 | Downstream write data |
| s_rsp_valid | input | 1 | Downstream response valid |
| s_rsp_rdata | input | 32 | Downstream read data |
| s_rsp_err | input | 1 | Downstream error flag |

## Verification
The hardest case to reach from the ports is a configuration change that races a request. The same edge can carry both a write that turns protection on and the acceptance of a request inside the new window. A request can also still be waiting on the downstream port when the window moves over its address. The stimulus reaches the first case by driving the write strobe and a request with downstream ready high in the same cycle. It reaches the second by holding back the downstream response for several cycles while protecting the in-flight address, then releasing the response and checking that it is delivered without an error. The boundary sweep runs every defined size code with the first and last bytes of the window and the bytes on either side of it.

// File: rtl/prf_pkg.sv
package prf_pkg;

    localparam int PRF_ADDR_W = 32;
    localparam int PRF_DATA_W = 32;
    localparam int PRF_CODE_W = 5;

    // configuration select values
    localparam logic PRF_SEL_BASE = 1'b0;
    localparam logic PRF_SEL_SIZE = 1'b1;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_FWD_WAIT = 2'd1,
        ST_ERR_RSP  = 2'd2
    } prf_state_e;

    typedef struct packed {
        logic [PRF_ADDR_W-1:0] base;
        logic [PRF_CODE_W-1:0] size_code;
    } prf_cfg_t;

    typedef struct packed {
        logic                  write;
        logic [PRF_ADDR_W-1:0] addr;
        logic [PRF_DATA_W-1:0] wdata;
    } prf_req_t;

    typedef struct packed {
        logic                  err;
        logic [PRF_DATA_W-1:0] rdata;
    } prf_rsp_t;

    // true for the size codes that describe a real window
    function automatic logic code_defined(input logic [PRF_CODE_W-1:0] code);
        case (code)
            5'd13, 5'd14, 5'd15, 5'd16, 5'd17, 5'd18, 5'd22: return 1'b1;
            default:                                         return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/prf_cfg_regs.sv
module prf_cfg_regs
    import prf_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic                  sel,
    input  logic [PRF_DATA_W-1:0] wdata,
    output prf_cfg_t              cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (we) begin
            if (sel == PRF_SEL_BASE) begin
                cfg.base <= wdata[PRF_ADDR_W-1:0];
            end else begin
                cfg.size_code <= wdata[PRF_CODE_W-1:0];
            end
        end
    end

endmodule

// File: rtl/prf_region_match.sv
module prf_region_match
    import prf_pkg::*;
#(
    parameter int ADDR_W = PRF_ADDR_W
) (
    input  prf_cfg_t          cfg,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);

    localparam int NB_W = $clog2(ADDR_W) + 1;

    logic [NB_W-1:0]   low_bits;
    logic [ADDR_W-1:0] keep;
    logic [ADDR_W-1:0] diff;

    // window of 2^(code+1) bytes: bits below code+1 are don't-care
    assign low_bits = NB_W'(cfg.size_code) + NB_W'(1);

    for (genvar gi = 0; gi < ADDR_W; gi++) begin : g_keep
        assign keep[gi] = (NB_W'(gi) >= low_bits);
    end

    assign diff = (addr ^ cfg.base[ADDR_W-1:0]) & keep;
    assign hit  = cfg.base[0] && code_defined(cfg.size_code) && (diff == '0);

endmodule

// File: rtl/prf_txn_ctrl.sv
module prf_txn_ctrl
    import prf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       m_req_valid,
    output logic       m_req_ready,
    input  logic       hit,
    output logic       s_req_valid,
    input  logic       s_req_ready,
    input  logic       s_rsp_valid,
    input  prf_rsp_t   s_rsp,
    output logic       m_rsp_valid,
    output prf_rsp_t   m_rsp
);

    prf_state_e state, state_nx;

    always_comb begin
        m_req_ready = 1'b0;
        s_req_valid = 1'b0;
        m_rsp_valid = 1'b0;
        m_rsp       = '0;
        state_nx    = state;
        unique case (state)
            ST_IDLE: begin
                if (hit) begin
                    m_req_ready = 1'b1;
                    if (m_req_valid) state_nx = ST_ERR_RSP;
                end else begin
                    s_req_valid = m_req_valid;
                    m_req_ready = s_req_ready;
                    if (m_req_valid && s_req_ready) state_nx = ST_FWD_WAIT;
                end
            end
            ST_FWD_WAIT: begin
                if (s_rsp_valid) begin
                    m_rsp_valid = 1'b1;
                    m_rsp       = s_rsp;
                    state_nx    = ST_IDLE;
                end
            end
            ST_ERR_RSP: begin
                m_rsp_valid = 1'b1;
                m_rsp.err   = 1'b1;
                state_nx    = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

endmodule

// File: rtl/prot_region_filter.sv
module prot_region_filter
    import prf_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic                  cfg_sel,
    input  logic [PRF_DATA_W-1:0] cfg_wdata,
    input  logic                  m_req_valid,
    output logic                  m_req_ready,
    input  logic [PRF_ADDR_W-1:0] m_req_addr,
    input  logic                  m_req_write,
    input  logic [PRF_DATA_W-1:0] m_req_wdata,
    output logic                  m_rsp_valid,
    output logic [PRF_DATA_W-1:0] m_rsp_rdata,
    output logic                  m_rsp_err,
    output logic                  s_req_valid,
    input  logic                  s_req_ready,
    output logic [PRF_ADDR_W-1:0] s_req_addr,
    output logic                  s_req_write,
    output logic [PRF_DATA_W-1:0] s_req_wdata,
    input  logic                  s_rsp_valid,
    input  logic [PRF_DATA_W-1:0] s_rsp_rdata,
    input  logic                  s_rsp_err
);

    prf_cfg_t cfg;
    prf_req_t req;
    prf_rsp_t dn_rsp;
    prf_rsp_t up_rsp;
    logic     req_hit;

    assign req = '{write: m_req_write, addr: m_req_addr, wdata: m_req_wdata};
    assign dn_rsp = '{err: s_rsp_err, rdata: s_rsp_rdata};

    prf_cfg_regs u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    prf_region_match #(.ADDR_W(PRF_ADDR_W)) u_match (
        .cfg  (cfg),
        .addr (req.addr),
        .hit  (req_hit)
    );

    prf_txn_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .m_req_valid (m_req_valid),
        .m_req_ready (m_req_ready),
        .hit         (req_hit),
        .s_req_valid (s_req_valid),
        .s_req_ready (s_req_ready),
        .s_rsp_valid (s_rsp_valid),
        .s_rsp       (dn_rsp),
        .m_rsp_valid (m_rsp_valid),
        .m_rsp       (up_rsp)
    );

    assign s_req_addr  = req.addr;
    assign s_req_write = req.write;
    assign s_req_wdata = req.wdata;
    assign m_rsp_rdata = up_rsp.rdata;
    assign m_rsp_err   = up_rsp.err;

endmodule

// File: rtl/prf_checker.sv
module prf_checker
    import prf_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  hit,
    input logic                  m_req_valid,
    input logic                  m_req_ready,
    input logic [PRF_ADDR_W-1:0] m_req_addr,
    input logic                  m_req_write,
    input logic                  m_rsp_valid,
    input logic [PRF_DATA_W-1:0] m_rsp_rdata,
    input logic                  m_rsp_err,
    input logic                  s_req_valid,
    input logic                  s_req_ready,
    input logic [PRF_ADDR_W-1:0] s_req_addr,
    input logic                  s_req_write,
    input logic                  s_rsp_valid,
    input logic [PRF_DATA_W-1:0] s_rsp_rdata,
    input logic                  s_rsp_err
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!m_rsp_valid && !s_req_valid));

    // R3
    blocked_no_fwd_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && m_req_valid) |-> !s_req_valid);

    // R3
    blocked_err_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        (m_req_valid && m_req_ready && hit) |=>
            (m_rsp_valid && m_rsp_err && m_rsp_rdata == '0));

    // R7
    fwd_payload_chk: assert property (@(posedge clk) disable iff (rst)
        s_req_valid |-> (s_req_addr == m_req_addr && s_req_write == m_req_write));

    // R8
    one_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
        (s_req_valid && s_req_ready) |=> !s_req_valid);

    // R8
    rsp_copy_chk: assert property (@(posedge clk) disable iff (rst)
        (s_rsp_valid && m_rsp_valid) |->
            (m_rsp_err == s_rsp_err && m_rsp_rdata == s_rsp_rdata));

endmodule

bind prot_region_filter prf_checker i_prf_checker (
    .clk         (clk),
    .rst         (rst),
    .hit         (req_hit),
    .m_req_valid (m_req_valid),
    .m_req_ready (m_req_ready),
    .m_req_addr  (m_req_addr),
    .m_req_write (m_req_write),
    .m_rsp_valid (m_rsp_valid),
    .m_rsp_rdata (m_rsp_rdata),
    .m_rsp_err   (m_rsp_err),
    .s_req_valid (s_req_valid),
    .s_req_ready (s_req_ready),
    .s_req_addr  (s_req_addr),
    .s_req_write (s_req_write),
    .s_rsp_valid (s_rsp_valid),
    .s_rsp_rdata (s_rsp_rdata),
    .s_rsp_err   (s_rsp_err)
);

// File: tb/test_prot_region_filter.sv
`timescale 1ns/1ps
module test_prot_region_filter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        m_req_valid = 1'b0, m_req_write = 1'b0;
    logic [31:0] m_req_addr = '0, m_req_wdata = '0;
    logic        m_req_ready, m_rsp_valid, m_rsp_err;
    logic [31:0] m_rsp_rdata;
    logic        s_req_valid, s_req_write;
    logic [31:0] s_req_addr, s_req_wdata;
    logic        s_req_ready = 1'b0, s_rsp_valid = 1'b0, s_rsp_err = 1'b0;
    logic [31:0] s_rsp_rdata = '0;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // bench-side copy of the configuration as software wrote it
    logic [31:0] mdl_base = '0;
    logic [4:0]  mdl_code = '0;

    always #4 clk = ~clk;

    prot_region_filter i_prot_region_filter (.*);

    function automatic bit mdl_blocked(input logic [31:0] a);
        bit defined;
        int n;
        defined = (mdl_code >= 13 && mdl_code <= 18) || mdl_code == 22;
        n = int'(mdl_code) + 1;
        return mdl_base[0] && defined && (((a ^ mdl_base) >> n) == 0);
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel == 1'b0) mdl_base = d; else mdl_code = d[4:0];
    endtask

    task automatic do_req(input logic [31:0] a, input bit wr, input bit ds_err,
                          input string req);
        bit blk = mdl_blocked(a);
        @(negedge clk);
        m_req_valid = 1'b1; m_req_addr = a; m_req_write = wr;
        m_req_wdata = a + 32'd5; s_req_ready = 1'b0;
        #1;
        if (blk) begin
            chk(req, "blocked s_req_valid", s_req_valid, 0);
            chk(req, "blocked ready", m_req_ready, 1);
            @(negedge clk);
            m_req_valid = 1'b0;
            #1;
            chk(req, "err rsp_valid", m_rsp_valid, 1);
            chk(req, "err flag", m_rsp_err, 1);
            chk(req, "err rdata", m_rsp_rdata, 0);
            chk(req, "err no fwd", s_req_valid, 0);
            @(negedge clk); #1;
            chk(req, "err rsp done", m_rsp_valid, 0);
        end else begin
            chk(req, "fwd valid", s_req_valid, 1);
            chk("R7", "fwd addr", s_req_addr, a);
            chk("R7", "fwd write", s_req_write, wr);
            chk("R7", "fwd wdata", s_req_wdata, a + 32'd5);
            chk("R7", "ready low", m_req_ready, 0);
            @(negedge clk);
            s_req_ready = 1'b1;
            #1;
            chk("R7", "ready high", m_req_ready, 1);
            @(negedge clk);
            m_req_valid = 1'b0; s_req_ready = 1'b0;
            #1;
            chk("R8", "no second req", s_req_valid, 0);
            chk("R8", "no early rsp", m_rsp_valid, 0);
            s_rsp_valid = 1'b1; s_rsp_rdata = ~a; s_rsp_err = ds_err;
            #1;
            chk("R8", "rsp valid", m_rsp_valid, 1);
            chk("R8", "rsp rdata", m_rsp_rdata, ~a);
            chk("R8", "rsp err", m_rsp_err, ds_err);
            @(negedge clk);
            s_rsp_valid = 1'b0; s_rsp_err = 1'b0;
            #1;
            chk("R8", "rsp done", m_rsp_valid, 0);
        end
    endtask

    task automatic t_reset;
        @(negedge clk); #1;
        chk("R1", "reset rsp_valid", m_rsp_valid, 0);
        chk("R1", "reset s_req_valid", s_req_valid, 0);
        do_req(32'h0000_1000, 1'b0, 1'b0, "R1");
    endtask

    task automatic t_disabled;
        cfg_write(1'b1, 32'd15);
        cfg_write(1'b0, 32'h2000_0000);
        do_req(32'h2000_0010, 1'b1, 1'b0, "R2");
        do_req(32'h2000_FFFC, 1'b0, 1'b1, "R2");
    endtask

    task automatic t_sizes;
        logic [4:0] codes [7] = '{5'd13, 5'd14, 5'd15, 5'd16, 5'd17, 5'd18, 5'd22};
        cfg_write(1'b0, 32'h4000_0001);
        foreach (codes[i]) begin
            logic [31:0] sz = 32'd1 << (int'(codes[i]) + 1);
            cfg_write(1'b1, {27'd0, codes[i]});
            do_req(32'h4000_0000, 1'b0, 1'b0, "R3");
            do_req(32'h4000_0000 + sz - 1, 1'b1, 1'b0, "R4");
            do_req(32'h4000_0000 + sz, 1'b0, 1'b0, "R4");
            do_req(32'h3FFF_FFFF, 1'b0, 1'b1, "R4");
        end
    endtask

    task automatic t_reserved;
        logic [4:0] codes [8] = '{5'd12, 5'd19, 5'd20, 5'd21, 5'd23, 5'd24, 5'd0, 5'd31};
        cfg_write(1'b0, 32'h4000_0001);
        foreach (codes[i]) begin
            cfg_write(1'b1, {27'd0, codes[i]});
            chk("R5", "model pass", 32'(mdl_blocked(32'h4000_0000)), 0);
            do_req(32'h4000_0000, 1'b0, 1'b0, "R5");
        end
    endtask

    task automatic t_lowbits;
        cfg_write(1'b1, 32'd15);
        cfg_write(1'b0, 32'h5000_FFFF);
        chk("R6", "model block", 32'(mdl_blocked(32'h5000_0000)), 1);
        do_req(32'h5000_0000, 1'b0, 1'b0, "R6");
        do_req(32'h5000_8000, 1'b1, 1'b0, "R6");
        do_req(32'h5001_0000, 1'b0, 1'b0, "R6");
    endtask

    task automatic t_cfg_sel;
        // size code from bits [4:0] only: upper junk ignored, code 15
        cfg_write(1'b1, 32'hFFFF_FFEF);
        cfg_write(1'b0, 32'h7000_0001);
        chk("R10", "model code", 32'(mdl_code), 15);
        do_req(32'h7000_FFF0, 1'b0, 1'b0, "R10");
        do_req(32'h7001_0000, 1'b0, 1'b0, "R10");
    endtask

    task automatic t_cfg_timing;
        cfg_write(1'b0, 32'h0000_0000);
        cfg_write(1'b1, 32'd15);
        // protection write and request acceptance on the same edge
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = 32'h6000_0001;
        m_req_valid = 1'b1; m_req_addr = 32'h6000_0100; m_req_write = 1'b0;
        s_req_ready = 1'b1;
        #1;
        chk("R9", "old cfg forwards", s_req_valid, 1);
        @(negedge clk);
        cfg_we = 1'b0; m_req_valid = 1'b0; s_req_ready = 1'b0;
        mdl_base = 32'h6000_0001;
        // hold the in-flight response for a few cycles
        repeat (3) @(negedge clk);
        #1;
        chk("R9", "in-flight no rsp", m_rsp_valid, 0);
        s_rsp_valid = 1'b1; s_rsp_rdata = 32'hA5A5_0001; s_rsp_err = 1'b0;
        #1;
        chk("R9", "in-flight rsp valid", m_rsp_valid, 1);
        chk("R9", "in-flight not rechecked", m_rsp_err, 0);
        chk("R9", "in-flight rdata", m_rsp_rdata, 32'hA5A5_0001);
        @(negedge clk);
        s_rsp_valid = 1'b0;
        chk("R9", "model now blocks", 32'(mdl_blocked(32'h6000_0100)), 1);
        do_req(32'h6000_0100, 1'b0, 1'b0, "R9");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_disabled();
        t_sizes();
        t_reserved();
        t_lowbits();
        t_cfg_sel();
        t_cfg_timing();
        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            finished = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule